// File: doc/BRIEF.md
# Touch-Panel Controller Serial Register Slave

This block is the two-wire serial (I2C) slave of a resistive touch-panel measurement controller. It watches SCL and SDA and recognises its own device address. A host can then load a register pointer, write configuration bytes, or read stored bytes back. After each byte the pointer steps forward by one, so burst transfers need no further addressing. Ports `sda_drive_low` and `scl_drive_low` each pull the open-drain line low when they are 1.

The block also handles reads aimed at a measurement channel. When the pointer lies in the channel window (20h to 29h) and a read begins, the slave asks an external converter for a fresh sample. It holds SCL low until the result arrives, then shifts the 12-bit value out left-justified in two bytes. If the host acknowledges the low byte, the slave runs another conversion on the same channel and sends two more bytes. This continues until the host sends NACK. The converter link is a pair of valid/ready channels. A request is held, with its channel number stable, until `conv_req_ready` accepts it. A result is taken in the cycle where both `conv_rslt_valid` and `conv_rslt_ready` are high. `conv_rslt_ready` is high only while a conversion is outstanding.

Top module: `tpc_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 1001 00 followed by the level of `dev_sel`. Bit 0 is the direction bit (1 = read). Any other address gets no acknowledge, and the slave ignores the bus until the next START.
- R2: The byte that follows a write address loads the register pointer from its low six bits. Its two upper bits are ignored. The slave acknowledges this byte and every write data byte.
- R3: After each data byte written, or each register byte read, the pointer advances by one. From 1Fh it wraps to 00h.
- R4: A written byte is committed on the rising SCL edge of its acknowledge clock, and not earlier. For the first data byte this is SCL rise 27 of the transfer. Register 01h drives `setup_cfg`.
- R5: A register read is made in four steps. The host writes the sub-address, sends a repeated START, and sends the read address. The slave then returns the byte at the pointer, one byte for each host ACK. Registers 01h to 1Fh hold the values written to them.
- R6: When a read begins with the pointer in 20h–29h, the slave requests a conversion on channel (pointer − 20h)/2: 0 = X, 1 = Y, 2 = Z1, 3 = Z2, 4 = IN. It sends result bits 11..4 first, then bits 3..0 followed by four zeros. The pointer does not move, and `cur_chan` shows the channel that was converted.
- R7: A host ACK after the low result byte starts a new conversion on the same channel, and its two bytes follow. This repeats until NACK.
- R8: Writing 01h to register 00h clears registers 01h–1Fh to 00h and returns `cur_chan` to X (0). Register 00h always reads 00h. After reset, `setup_cfg` and `cur_chan` are 0.
- R9: A conversion request stays valid, with `conv_chan` stable, until it is accepted. SCL is held low from the request until the result is taken.
- R10: A STOP releases both SDA and SCL. A NACK on a read byte makes the slave ignore all clocks until the next START.
- R11: The slave changes its SDA drive only while SCL is low, apart from the release at START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel | input | 1 | Lowest device address bit |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low |
| conv_req_valid | output | 1 | Conversion request valid |
| conv_req_ready | input | 1 | Converter accepts request |
| conv_chan | output | 3 | Channel of the request |
| conv_rslt_valid | input | 1 | Conversion result valid |
| conv_rslt_ready | output | 1 | Slave is waiting for a result |
| conv_rslt_data | input | 12 | Conversion result |
| setup_cfg | output | 8 | Contents of register 01h |
| cur_chan | output | 3 | Channel of the latest conversion |

## Verification
The hardest state to reach is a continuous conversion stream. Here the host's ACK on a low result byte must turn straight into a new stretched request. The next high byte must then go out with SCL still held by the slave. The bench reaches this state with a bit-level open-drain host model that waits for SCL to rise before it samples, and with a converter stub that answers about twenty cycles late. The stub's sample counter makes each answer in the stream different, so a repeated or stale result shows up. A NACK followed by a full byte of clocks without a START checks that the slave has truly let go of the bus.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int PTR_W  = 6;
  localparam int CHAN_W = 3;
  localparam logic [PTR_W-1:0] CHAN_BASE  = 6'h20;
  localparam logic [5:0]       DEV_PREFIX = 6'b100100;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_SUB, ST_SUB_ACK,
    ST_WR, ST_WR_ACK, ST_TX, ST_TX_ACK, ST_CONV
  } bus_state_e;
endpackage

// File: rtl/tpc_bus_sync.sv
module tpc_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin scl_ff <= '1; sda_ff <= '1; end
        else begin scl_ff <= scl_in; sda_ff <= sda_in; end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin scl_ff <= '1; sda_ff <= '1; end
        else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_in};
          sda_ff <= {sda_ff[STAGES-2:0], sda_in};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin scl_q <= 1'b1; sda_q <= 1'b1; end
    else begin scl_q <= scl_ff[STAGES-1]; sda_q <= sda_ff[STAGES-1]; end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/tpc_regfile.sv
module tpc_regfile #(
  parameter int DEPTH = 32,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          clr_pulse,
  output logic [7:0]    setup_cfg
);
  localparam int IW = $clog2(DEPTH);
  logic [7:0] regs [DEPTH];

  assign clr_pulse = wr_en && (wr_addr == '0) && (wr_data == 8'h01);

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
      if (i == 0) begin : g_cmd
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) regs[i] <= '0;
          else        regs[i] <= '0;
      end else begin : g_data
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n)                             regs[i] <= '0;
          else if (clr_pulse)                     regs[i] <= '0;
          else if (wr_en && wr_addr == AW'(i))    regs[i] <= wr_data;
      end
    end
  endgenerate

  assign rd_data   = ({1'b0, rd_addr} < (AW+1)'(DEPTH)) ? regs[rd_addr[IW-1:0]] : 8'h00;
  assign setup_cfg = regs[1];

  // R8
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> setup_cfg == 8'h00);
endmodule

// File: rtl/tpc_i2c_fsm.sv
module tpc_i2c_fsm
  import tpc_pkg::*;
#(
  parameter int REG_DEPTH = 32,
  parameter int ADC_W     = 12,
  parameter int CH_CNT    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_sel,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [7:0]        rd_data,
  input  logic              clr_pulse,
  output logic [PTR_W-1:0]  rd_addr,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [7:0]        wr_data,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              conv_req_valid,
  input  logic              conv_req_ready,
  output logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_rslt_valid,
  output logic              conv_rslt_ready,
  input  logic [ADC_W-1:0]  conv_rslt_data,
  output logic [CHAN_W-1:0] cur_chan
);
  localparam int LO_W = ADC_W - 8;
  localparam logic [PTR_W-1:0] WRAP_AT = PTR_W'(REG_DEPTH - 1);
  localparam logic [PTR_W-1:0] CH_END  = CHAN_BASE + PTR_W'(2 * CH_CNT);

  bus_state_e        state;
  logic [3:0]        cnt;
  logic [7:0]        sh;
  logic [PTR_W-1:0]  ptr;
  logic              conv_mode, lo_next, req_sent;
  logic [LO_W-1:0]   lo_bits;
  logic [CHAN_W-1:0] chan_q, cur_chan_q;

  logic              chan_hit;
  logic [PTR_W-1:0]  ptr_off, ptr_inc;
  logic [CHAN_W-1:0] ptr_chan;

  always_comb begin
    chan_hit = (ptr >= CHAN_BASE) && (ptr < CH_END);
    ptr_off  = ptr - CHAN_BASE;
    ptr_chan = ptr_off[CHAN_W:1];
    ptr_inc  = (ptr == WRAP_AT) ? '0 : ptr + 1'b1;
  end

  assign rd_addr         = ptr;
  assign wr_en           = (state == ST_WR_ACK) && scl_rise;
  assign wr_addr         = ptr;
  assign wr_data         = sh;
  assign conv_req_valid  = (state == ST_CONV) && !req_sent;
  assign conv_rslt_ready = (state == ST_CONV) && req_sent;
  assign conv_chan       = chan_q;
  assign cur_chan        = cur_chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; sh <= '0; ptr <= '0;
      sda_oe <= 1'b0; scl_oe <= 1'b0;
      conv_mode <= 1'b0; lo_next <= 1'b0; req_sent <= 1'b0;
      lo_bits <= '0; chan_q <= '0; cur_chan_q <= '0;
    end else if (start_det) begin
      state <= ST_DEV; cnt <= '0;
      sda_oe <= 1'b0; scl_oe <= 1'b0; req_sent <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE; sda_oe <= 1'b0; scl_oe <= 1'b0;
    end else begin
      if (clr_pulse) cur_chan_q <= '0;
      case (state)
        ST_DEV, ST_SUB, ST_WR: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_lvl};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (state == ST_DEV && sh[7:1] != {DEV_PREFIX, dev_sel}) begin
              state <= ST_IDLE;
            end else begin
              sda_oe <= 1'b1;
              state  <= (state == ST_DEV) ? ST_DEV_ACK :
                        (state == ST_SUB) ? ST_SUB_ACK : ST_WR_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            if (!sh[0]) begin
              state <= ST_SUB;
            end else if (chan_hit) begin
              conv_mode <= 1'b1; lo_next <= 1'b0; req_sent <= 1'b0;
              chan_q <= ptr_chan; scl_oe <= 1'b1; state <= ST_CONV;
            end else begin
              conv_mode <= 1'b0;
              sh <= rd_data; sda_oe <= ~rd_data[7]; state <= ST_TX;
            end
          end
        end
        ST_SUB_ACK: begin
          if (scl_rise) ptr <= sh[PTR_W-1:0];
          else if (scl_fall) begin sda_oe <= 1'b0; state <= ST_WR; end
        end
        ST_WR_ACK: begin
          if (scl_rise) ptr <= ptr_inc;
          else if (scl_fall) begin sda_oe <= 1'b0; state <= ST_WR; end
        end
        ST_TX: begin
          if (scl_rise) cnt <= cnt + 1'b1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0; state <= ST_TX_ACK;
            end else begin
              sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            if (sda_lvl)         state <= ST_IDLE;
            else if (!conv_mode) ptr <= ptr_inc;
          end else if (scl_fall) begin
            cnt <= '0;
            if (conv_mode && lo_next) begin
              sh <= {lo_bits, {(8-LO_W){1'b0}}};
              sda_oe <= ~lo_bits[LO_W-1]; lo_next <= 1'b0; state <= ST_TX;
            end else if (conv_mode) begin
              req_sent <= 1'b0; scl_oe <= 1'b1; state <= ST_CONV;
            end else begin
              sh <= rd_data; sda_oe <= ~rd_data[7]; state <= ST_TX;
            end
          end
        end
        ST_CONV: begin
          if (!req_sent && conv_req_ready) req_sent <= 1'b1;
          if (req_sent && conv_rslt_valid) begin
            sh         <= conv_rslt_data[ADC_W-1 -: 8];
            lo_bits    <= conv_rslt_data[LO_W-1:0];
            sda_oe     <= ~conv_rslt_data[ADC_W-1];
            cur_chan_q <= chan_q;
            lo_next    <= 1'b1;
            scl_oe     <= 1'b0;
            cnt        <= '0;
            state      <= ST_TX;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_valid && !conv_req_ready |=> conv_req_valid && $stable(conv_chan));
  // R9
  stretch_during_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_valid |-> scl_oe);
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe && !scl_oe);
  // R11
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) && !$past(stop_det) && !$past(start_det) |-> !scl_lvl);
endmodule

// File: rtl/tpc_i2c_slave.sv
module tpc_i2c_slave
  import tpc_pkg::*;
#(
  parameter int REG_DEPTH   = 32,
  parameter int ADC_W       = 12,
  parameter int CH_CNT      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_sel,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              conv_req_valid,
  input  logic              conv_req_ready,
  output logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_rslt_valid,
  output logic              conv_rslt_ready,
  input  logic [ADC_W-1:0]  conv_rslt_data,
  output logic [7:0]        setup_cfg,
  output logic [CHAN_W-1:0] cur_chan
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic wr_en, clr_pulse;

  tpc_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  tpc_regfile #(.DEPTH(REG_DEPTH), .AW(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .clr_pulse(clr_pulse), .setup_cfg(setup_cfg)
  );

  tpc_i2c_fsm #(.REG_DEPTH(REG_DEPTH), .ADC_W(ADC_W), .CH_CNT(CH_CNT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .clr_pulse(clr_pulse), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_oe(sda_drive_low), .scl_oe(scl_drive_low),
    .conv_req_valid(conv_req_valid), .conv_req_ready(conv_req_ready),
    .conv_chan(conv_chan), .conv_rslt_valid(conv_rslt_valid),
    .conv_rslt_ready(conv_rslt_ready), .conv_rslt_data(conv_rslt_data),
    .cur_chan(cur_chan)
  );
endmodule

// File: tb/tb_tpc_i2c_slave.sv
module tb_tpc_i2c_slave;
  localparam int H = 40;
  localparam logic [7:0] AW_BYTE = 8'h92;
  localparam logic [7:0] AR_BYTE = 8'h93;
  localparam logic [15:0] VEC [8] = '{16'h015A, 16'h02C3, 16'h0511, 16'h0AFF,
                                      16'h1000, 16'h1F81, 16'h073C, 16'h1CE7};

  logic clk = 1'b0;
  logic rst_n, dev_sel, m_scl_low, m_sda_low;
  logic scl_drive_low, sda_drive_low;
  logic conv_req_valid, conv_req_ready, conv_rslt_valid, conv_rslt_ready;
  logic [2:0] conv_chan, cur_chan;
  logic [11:0] conv_rslt_data;
  logic [7:0] setup_cfg;
  logic scl_line, sda_line;

  int checks = 0, errors = 0;
  int stretch = 0, req_count = 0, conv_num = 0, viol = 0;
  logic [2:0] stub_chan;
  logic [7:0] cfg_pre, cfg_post;

  always #4 clk = ~clk;
  assign scl_line = !(m_scl_low || scl_drive_low);
  assign sda_line = !(m_sda_low || sda_drive_low);

  tpc_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .scl_in(scl_line), .sda_in(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .conv_req_valid(conv_req_valid), .conv_req_ready(conv_req_ready),
    .conv_chan(conv_chan), .conv_rslt_valid(conv_rslt_valid),
    .conv_rslt_ready(conv_rslt_ready), .conv_rslt_data(conv_rslt_data),
    .setup_cfg(setup_cfg), .cur_chan(cur_chan)
  );

  function automatic logic [11:0] sample_val(input logic [2:0] ch, input int n);
    return {4'(ch + 3'd1), 8'(n * 37 + 19)};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter stub and line monitors
  initial begin
    conv_req_ready = 1'b1; conv_rslt_valid = 1'b0; conv_rslt_data = '0;
    forever begin
      @(negedge clk);
      if (conv_req_valid) begin
        stub_chan = conv_chan; req_count++;
        tick(20);
        conv_rslt_data = sample_val(stub_chan, conv_num);
        conv_rslt_valid = 1'b1;
        @(negedge clk);
        conv_rslt_valid = 1'b0;
        conv_num++;
      end
    end
  end

  initial begin
    logic prev_oe = 1'b0;
    forever begin
      @(negedge clk);
      if (scl_drive_low) stretch++;
      if (sda_drive_low !== prev_oe && scl_line) viol++;
      prev_oe = sda_drive_low;
    end
  end

  task automatic clock_bit(output logic smp);
    tick(H);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    tick(H);
    smp = sda_line;
    m_scl_low = 1'b1;
    tick(4);
  endtask

  task automatic bus_start();
    if (m_scl_low) begin
      m_sda_low = 1'b0; tick(H);
      m_scl_low = 1'b0;
      while (!scl_line) @(negedge clk);
      tick(H);
    end
    m_sda_low = 1'b1; tick(H);
    m_scl_low = 1'b1; tick(4);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; tick(H);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    tick(H);
    m_sda_low = 1'b0; tick(H);
  endtask

  task automatic byte_write(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = !b[i];
      clock_bit(s);
    end
    m_sda_low = 1'b0;
    tick(H);
    cfg_pre = setup_cfg;
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    tick(H);
    acked = !sda_line;
    m_scl_low = 1'b1;
    tick(4);
    cfg_post = setup_cfg;
  endtask

  task automatic byte_read(input logic ack, output logic [7:0] b);
    logic s;
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(s);
      b[i] = s;
    end
    m_sda_low = ack;
    clock_bit(s);
    m_sda_low = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] sub, input logic [7:0] d);
    logic a;
    bus_start();
    byte_write(AW_BYTE, a); chk("R1 address ack", 32'(a), 1);
    byte_write(sub, a);     chk("R2 sub ack", 32'(a), 1);
    byte_write(d, a);
    bus_stop();
  endtask

  task automatic open_read(input logic [7:0] sub);
    logic a;
    bus_start();
    byte_write(AW_BYTE, a);
    byte_write(sub, a);
    bus_start();
    byte_write(AR_BYTE, a);
  endtask

  task automatic rd_reg(input logic [7:0] sub, output logic [7:0] b);
    open_read(sub);
    byte_read(1'b0, b);
    bus_stop();
  endtask

  initial begin
    int exp_n = 0;
    int st0;
    logic a;
    logic [7:0] b, hi, lo;
    logic [11:0] v;
    rst_n = 1'b0; dev_sel = 1'b1; m_scl_low = 1'b0; m_sda_low = 1'b0;
    tick(10); rst_n = 1'b1; tick(10);
    chk("R8 reset cfg", 32'(setup_cfg), 0);
    chk("R8 reset chan", 32'(cur_chan), 0);
    chk("R10 sda idle", 32'(sda_drive_low), 0);
    chk("R10 scl idle", 32'(scl_drive_low), 0);

    // R1: wrong device address gets no acknowledge
    bus_start(); byte_write(8'h90, a); chk("R1 mismatch nack", 32'(a), 0); bus_stop();

    // R5: table of write/read-back vectors
    for (int i = 0; i < 8; i++) begin
      wr_reg(VEC[i][15:8], VEC[i][7:0]);
      rd_reg(VEC[i][15:8], b);
      chk("R5 read back", 32'(b), 32'(VEC[i][7:0]));
    end

    // R4: commit on the acknowledge clock of the data byte
    wr_reg(8'h01, 8'h66);
    chk("R4 before ack rise", 32'(cfg_pre), 32'h5A);
    chk("R4 after ack rise", 32'(cfg_post), 32'h66);

    // R2: upper sub-address bits ignored
    wr_reg(8'hC7, 8'h29);
    rd_reg(8'h07, b); chk("R2 masked sub", 32'(b), 32'h29);

    // R3: burst write across the 1Fh wrap
    bus_start(); byte_write(AW_BYTE, a); byte_write(8'h1E, a);
    byte_write(8'hA1, a); byte_write(8'hB2, a); byte_write(8'h00, a); byte_write(8'h4D, a);
    bus_stop();
    chk("R3 wrap write", 32'(setup_cfg), 32'h4D);
    open_read(8'h1E);
    byte_read(1'b1, b); chk("R3 burst 1E", 32'(b), 32'hA1);
    byte_read(1'b1, b); chk("R3 burst 1F", 32'(b), 32'hB2);
    byte_read(1'b1, b); chk("R3 burst 00", 32'(b), 32'h00);
    byte_read(1'b0, b); chk("R3 burst 01", 32'(b), 32'h4D);
    bus_stop();

    // R6: single conversion on Z1
    open_read(8'h24);
    st0 = stretch;
    byte_read(1'b1, hi); byte_read(1'b0, lo); bus_stop();
    v = sample_val(3'd2, exp_n); exp_n++;
    chk("R6 high byte", 32'(hi), 32'(v[11:4]));
    chk("R6 low byte", 32'(lo), 32'({v[3:0], 4'h0}));
    chk("R6 cur_chan", 32'(cur_chan), 2);
    chk("R6 request chan", 32'(stub_chan), 2);
    chk("R9 stretched", 32'(stretch > st0), 1);

    // R7: continuous stream on X
    open_read(8'h20);
    for (int k = 0; k < 3; k++) begin
      byte_read(1'b1, hi); byte_read(k < 2, lo);
      v = sample_val(3'd0, exp_n); exp_n++;
      chk("R7 stream high", 32'(hi), 32'(v[11:4]));
      chk("R7 stream low", 32'(lo), 32'({v[3:0], 4'h0}));
    end
    bus_stop();
    chk("R7 stream chan", 32'(cur_chan), 0);

    // R6: odd pointer in IN pair
    open_read(8'h29);
    byte_read(1'b1, hi); byte_read(1'b0, lo); bus_stop();
    v = sample_val(3'd4, exp_n); exp_n++;
    chk("R6 IN high", 32'(hi), 32'(v[11:4]));
    chk("R6 IN chan", 32'(cur_chan), 4);
    chk("R9 request count", 32'(req_count), 32'(exp_n));

    // R10: after NACK, clocks without START are ignored
    open_read(8'h05);
    byte_read(1'b0, b);
    byte_write(AW_BYTE, a); chk("R10 ignored after nack", 32'(a), 0);
    bus_stop();
    rd_reg(8'h05, b); chk("R10 bus usable again", 32'(b), 32'h11);

    // R8: reset command
    wr_reg(8'h00, 8'h01);
    chk("R8 cfg cleared", 32'(setup_cfg), 0);
    chk("R8 chan to X", 32'(cur_chan), 0);
    rd_reg(8'h1E, b); chk("R8 reg cleared", 32'(b), 0);
    rd_reg(8'h00, b); chk("R8 reg00 reads zero", 32'(b), 0);

    // R11: SDA drive changes only with SCL low
    chk("R11 sda change phase", 32'(viol), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(190000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule